// File: doc/BRIEF.md
# Watchdog Wake-Up Reset Supervisor

This block supervises a microcontroller that spends most of its time asleep. It drives a free-running wake-up square wave to rouse the controller. The controller answers each wake-up by giving a falling edge on the watchdog input. A falling edge in the high phase of a wake-up cycle ends that high phase early. A cycle that ends with no falling edge gives an active-low reset pulse, and the wake-up timing then restarts after a fixed delay.

The same active-low reset is held while the supply-good flag is low, at power-up or after a later drop. It is then released after the reset delay. Every interval is a whole number of base ticks, and one parameter sets the tick length. The wake-up period, the reset pulse and the delay from reset release to the first wake-up keep the ratio 4 : 0.5 : 2. The supply-good flag arrives synchronised and filtered. The watchdog input may be asynchronous.

Top module: `wdw_wake_supervisor`

## Requirements
- R1: While the asynchronous clear is asserted (low), `rst_no` is 0 and `wake_o` is 0.
- R2: While `pwr_ok_i` is 0, `rst_no` stays 0. After `pwr_ok_i` goes to 1, `rst_no` rises on the RL-th rising clock edge at which `pwr_ok_i` is sampled high, where RL = TICK_CYC clock cycles (one base tick).
- R3: After `rst_no` rises, `wake_o` stays 0 for exactly DL = 4*TICK_CYC clock cycles and then rises. That rising edge starts the first wake-up cycle.
- R4: A wake-up cycle lasts P = 8*TICK_CYC clock cycles. If no watchdog falling edge occurs in the high phase, `wake_o` is 1 for the first P/2 cycles and 0 for the last P/2 cycles, a 50% duty cycle.
- R5: The first falling edge of `wdi_i` (1 to 0) in the high phase drives `wake_o` to 0 by the third rising clock edge after the input changes. `wake_o` then stays 0 until the next cycle starts, P cycles after the previous start.
- R6: Further falling edges in the same cycle have no effect. Rising edges and a steady level of `wdi_i` are not watchdog events.
- R7: A cycle with no counted falling edge ends with `rst_no` going to 0 at the cycle end. It stays 0 for RL cycles, and then the R3 delay follows. A falling edge whose event reaches the sequencer on the last edge of the cycle still counts.
- R8: When `pwr_ok_i` is sampled 0 in any state, `rst_no` is 0 after that edge. `wake_o` is 0 whenever `rst_no` is 0.
- R9: One input fall is counted once. It credits only the cycle it lands in, and holding `wdi_i` low into the next cycle does not credit that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous power-on clear, active low |
| pwr_ok_i | input | 1 | Synchronised, filtered supply-good flag |
| wdi_i | input | 1 | Watchdog input from the controller; falling edges count |
| rst_no | output | 1 | Reset output, active low |
| wake_o | output | 1 | Wake-up square wave |

## Verification
The hardest cases from the ports are the edges of the cycle window. One is a fall whose synchronised event arrives on the very edge at which the low phase expires. Another is a fall held as a low level across a cycle boundary, which must not credit the second cycle. The stimulus counts clock cycles from each observed wake-up rising edge and places falls at exact offsets: directed falls at the last counted slot and as held levels, and random falls in the high and low phases. Each measured phase length, including reset and post-reset delay lengths after misses and supply drops, is checked against lengths computed from the tick ratio.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [1:0] {
    ST_RST  = 2'd0,
    ST_POST = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } wdw_state_e;

  // fixed interval ratios in base ticks (reset pulse = 1 tick)
  localparam int unsigned RST_TICKS    = 1;
  localparam int unsigned DLY_TICKS    = 4;
  localparam int unsigned PERIOD_TICKS = 8;
  localparam int unsigned HALF_TICKS   = PERIOD_TICKS / 2;

  function automatic int unsigned span_cycles(input int unsigned ticks,
                                              input int unsigned tick_cyc);
    return ticks * tick_cyc;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdw_wdi_edge.sv
module wdw_wdi_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic wdi_i,
  output logic fall_ev_o
);
  // pipe[SYNC_STAGES-1] is the synchronised sample, pipe[SYNC_STAGES] the one before
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) pipe <= '1;
    else          pipe <= {pipe[SYNC_STAGES-1:0], wdi_i};
  end

  assign fall_ev_o = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];

  // R9: one input fall yields a single-cycle event
  p_single_event_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
    fall_ev_o |=> !fall_ev_o);

endmodule

// File: rtl/wdw_timer.sv
module wdw_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned INIT    = 0,
  parameter int unsigned MAX_LD  = 255
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)          cnt <= CW'(INIT);
    else if (load_i)       cnt <= load_val_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

  // R2: the count never exceeds the longest interval loaded
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
    cnt <= CW'(MAX_LD));

endmodule

// File: rtl/wdw_seq.sv
module wdw_seq
  import wdw_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned RST_LEN  = 8,
  parameter int unsigned DLY_LEN  = 32,
  parameter int unsigned HALF_LEN = 32
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          pwr_ok_i,
  input  logic          ev_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          rst_no,
  output logic          wake_o
);
  localparam logic [CW-1:0] RST_LD  = CW'(RST_LEN - 1);
  localparam logic [CW-1:0] DLY_LD  = CW'(DLY_LEN - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF_LEN - 1);

  wdw_state_e state, state_nx;
  logic       seen;
  logic       cycle_start;
  logic       in_window;

  always_comb begin
    state_nx   = state;
    tmr_load_o = 1'b0;
    tmr_val_o  = RST_LD;
    unique case (state)
      ST_RST: begin
        if (!pwr_ok_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = RST_LD;
        end else if (tmr_done_i) begin
          state_nx   = ST_POST;
          tmr_load_o = 1'b1;
          tmr_val_o  = DLY_LD;
        end
      end
      ST_POST: if (tmr_done_i) begin
        state_nx   = ST_HI;
        tmr_load_o = 1'b1;
        tmr_val_o  = HALF_LD;
      end
      ST_HI: if (tmr_done_i) begin
        state_nx   = ST_LO;
        tmr_load_o = 1'b1;
        tmr_val_o  = HALF_LD;
      end
      ST_LO: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        if (seen || ev_i) begin
          state_nx  = ST_HI;
          tmr_val_o = HALF_LD;
        end else begin
          state_nx  = ST_RST;
          tmr_val_o = RST_LD;
        end
      end
      default: begin
        state_nx   = ST_RST;
        tmr_load_o = 1'b1;
      end
    endcase
    if (!pwr_ok_i && state != ST_RST) begin
      state_nx   = ST_RST;
      tmr_load_o = 1'b1;
      tmr_val_o  = RST_LD;
    end
  end

  assign cycle_start = (state_nx == ST_HI) && (state != ST_HI);
  assign in_window   = (state == ST_HI) || (state == ST_LO);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      state <= ST_RST;
      seen  <= 1'b0;
    end else begin
      state <= state_nx;
      if (cycle_start || state_nx == ST_RST) seen <= 1'b0;
      else if (ev_i && in_window)            seen <= 1'b1;
    end
  end

  assign rst_no = (state != ST_RST);
  assign wake_o = (state == ST_HI) && !seen;

  // R8: a bad supply sample forces reset on the next cycle
  p_supply_drop_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !pwr_ok_i |=> !rst_no);

  // R8: no wake-up while reset is driven
  p_wake_in_reset_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !rst_no |-> !wake_o);

  // R5: first event in the high phase pulls wake-up low on the next cycle
  p_first_event_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (state == ST_HI && ev_i && !seen && !tmr_done_i && pwr_ok_i) |=> !wake_o);

  // R7: an expired cycle with no event ends in reset
  p_missed_cycle_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (state == ST_LO && tmr_done_i && !seen && !ev_i) |=> !rst_no);

  // R3: wake-up rises only when an interval expires
  p_wake_rise_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(wake_o) |-> $past(tmr_done_i));

endmodule

// File: rtl/wdw_wake_supervisor.sv
module wdw_wake_supervisor #(
  parameter int unsigned TICK_CYC    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pwr_ok_i,
  input  logic wdi_i,
  output logic rst_no,
  output logic wake_o
);
  localparam int unsigned RST_LEN  = wdw_pkg::span_cycles(wdw_pkg::RST_TICKS, TICK_CYC);
  localparam int unsigned DLY_LEN  = wdw_pkg::span_cycles(wdw_pkg::DLY_TICKS, TICK_CYC);
  localparam int unsigned HALF_LEN = wdw_pkg::span_cycles(wdw_pkg::HALF_TICKS, TICK_CYC);
  localparam int unsigned MAX_LEN  = wdw_pkg::max3(RST_LEN, DLY_LEN, HALF_LEN);
  localparam int unsigned CW       = $clog2(MAX_LEN) + 1;

  logic          fall_ev;
  logic          tmr_done;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  wdw_wdi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .arst_ni   (arst_ni),
    .wdi_i     (wdi_i),
    .fall_ev_o (fall_ev)
  );

  wdw_timer #(.CW(CW), .INIT(RST_LEN - 1), .MAX_LD(MAX_LEN - 1)) u_timer (
    .clk_i      (clk_i),
    .arst_ni    (arst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  wdw_seq #(.CW(CW), .RST_LEN(RST_LEN), .DLY_LEN(DLY_LEN), .HALF_LEN(HALF_LEN)) u_seq (
    .clk_i      (clk_i),
    .arst_ni    (arst_ni),
    .pwr_ok_i   (pwr_ok_i),
    .ev_i       (fall_ev),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .rst_no     (rst_no),
    .wake_o     (wake_o)
  );

  // R1: outputs are low whenever the clear is held
  always_comb begin
    if (!arst_ni) p_clear_outputs_r1: assert (!rst_no && !wake_o);
  end

endmodule

// File: tb/wdw_wake_supervisor_bench.sv
`timescale 1ns/1ps
module wdw_wake_supervisor_bench;
  localparam int TICK = 8;
  localparam int RL   = TICK;       // reset pulse: 0.5 of the ratio unit
  localparam int DL   = 4 * TICK;   // 2 units
  localparam int P    = 8 * TICK;   // 4 units
  localparam int H    = P / 2;

  logic clk = 1'b0;
  logic arst_n, pwr_ok, wdi;
  logic rst_n, wake;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  wdw_wake_supervisor #(.TICK_CYC(TICK)) u_wdw_wake_supervisor (
    .clk_i(clk), .arst_ni(arst_n), .pwr_ok_i(pwr_ok), .wdi_i(wdi),
    .rst_no(rst_n), .wake_o(wake)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int f);
    return (f > 0 && f + 3 < H) ? f + 3 : H;
  endfunction

  task automatic wait_change(input bit sel_rst, output int n);
    logic v0;
    v0 = sel_rst ? rst_n : wake;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((sel_rst ? rst_n : wake) == v0) && n < 1000);
  endtask

  // starts at a negedge where wake has just been seen high
  task automatic run_cycle(input int f1, input int r1, input int f2, input int r2,
                           output int hi, output int tot, output bit hit);
    int n;
    n = 0; hi = 0; tot = 0; hit = 1'b0;
    while (tot == 0) begin
      @(negedge clk);
      n++;
      if (!rst_n) begin hit = 1'b1; tot = n; end
      else if (hi == 0 && !wake) hi = n;
      else if (hi != 0 && wake) tot = n;
      if (n >= 4 * P) tot = n;
      if (tot == 0) begin
        if (n == f1) wdi = 1'b0;
        if (n == r1) wdi = 1'b1;
        if (n == f2) wdi = 1'b0;
        if (n == r2) wdi = 1'b1;
      end
    end
  endtask

  task automatic recover(input string req);
    int n;
    wait_change(1'b1, n);
    chk({req, " reset width"}, n, RL);
    chk({req, " wake low at release"}, int'(wake), 0);
    wait_change(1'b0, n);
    chk({"R3 delay after ", req}, n, DL);
  endtask

  task automatic cyc(input string req, input int f1, input int r1, input int f2,
                     input int r2, input int first_fall, input bit exp_hit);
    int hi, tot;
    bit hit;
    run_cycle(f1, r1, f2, r2, hi, tot, hit);
    chk({req, " high length"}, hi, exp_hi(first_fall));
    chk({req, " cycle length"}, tot, P);
    chk({req, " reset taken"}, int'(hit), int'(exp_hit));
    if (exp_hit) recover(req);
  endtask

  initial begin
    int n, kind, f1, r1, f2, r2;
    void'($urandom(32'h5EED_1234));
    arst_n = 1'b0; pwr_ok = 1'b0; wdi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset out during clear", int'(rst_n), 0);
    chk("R1 wake out during clear", int'(wake), 0);
    arst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 held while supply bad", int'(rst_n), 0);
    chk("R8 wake low while supply bad", int'(wake), 0);
    pwr_ok = 1'b1;
    wait_change(1'b1, n);
    chk("R2 release delay", n, RL);
    wait_change(1'b0, n);
    chk("R3 first wake delay", n, DL);

    cyc("R4 low-phase service", H + 4, H + 6, 0, 0, H + 4, 1'b0);
    cyc("R4 second cycle", H + 10, H + 11, 0, 0, H + 10, 1'b0);
    cyc("R5 early fall", 5, 7, 0, 0, 5, 1'b0);
    cyc("R5 last high slot", H - 4, H - 2, 0, 0, H - 4, 1'b0);
    cyc("R6 extra falls", 3, 5, H + 2, H + 4, 3, 1'b0);
    cyc("R6 extra fall in high", 4, 6, 9, 11, 4, 1'b0);
    cyc("R7 fall at window end", P - 3, P - 1, 0, 0, P - 3, 1'b0);
    cyc("R7 missed cycle", 0, 0, 0, 0, 0, 1'b1);
    cyc("R9 fall held low", H + 2, 0, 0, 0, H + 2, 1'b0);
    cyc("R9 level and rise only", 0, 10, 0, 0, 0, 1'b1);

    // R8: supply drop in the middle of a high phase
    repeat (5) @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R8 reset after drop", int'(rst_n), 0);
    chk("R8 wake after drop", int'(wake), 0);
    repeat (10) @(negedge clk);
    chk("R8 reset held", int'(rst_n), 0);
    pwr_ok = 1'b1;
    recover("R2 after drop");

    for (int i = 0; i < 40; i++) begin
      kind = int'($urandom % 8);
      f2 = 0; r2 = 0;
      if (kind < 3) begin
        f1 = H + int'($urandom % (H - 6)); r1 = f1 + 2;
        cyc("R4 random low", f1, r1, 0, 0, f1, 1'b0);
      end else if (kind < 5) begin
        f1 = 1 + int'($urandom % (H - 5)); r1 = f1 + 1 + int'($urandom % 3);
        cyc("R5 random high", f1, r1, 0, 0, f1, 1'b0);
      end else if (kind < 7) begin
        f1 = 1 + int'($urandom % (H - 5)); r1 = f1 + 2;
        f2 = r1 + 2 + int'($urandom % (P - r1 - 10)); r2 = f2 + 2;
        cyc("R6 random repeat", f1, r1, f2, r2, f1, 1'b0);
      end else begin
        cyc("R7 random miss", 0, 0, 0, 0, 0, 1'b1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule